// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a CPU virtual address into a physical address by reading one entry of a linear page table that sits in physical memory. Two configuration registers describe the current address space. One holds the byte address where the table starts. The other holds how many entries the table has. The virtual address splits into a virtual page number (upper bits) and a byte offset (lower bits, whose width comes from the page-size parameter).

For each accepted request the block compares the page number with the table length. A page number inside the table leads to one memory read of the entry. The result is the frame number from that entry with the untouched offset placed below it. A page number outside the table, or an entry whose valid bit is clear, returns an error status instead.

Only one translation is in flight at a time. A configuration write that arrives while a translation is running is parked and takes effect once the block is idle again.

Top module: `pt_walker`

## Requirements
- R1: For a successful translation, `rsp_paddr` equals the entry's frame field (bits FRAME_W-1:0 of the entry word) shifted above the offset, and the low log2(PAGE_BYTES) bits equal those of the request address unchanged. With 4-byte pages, a table mapping page 0 to frame 4, page 1 to frame 3 and page 2 to frame 1 translates 0x6 to 0xE and 0x9 to 0x5.
- R2: An in-bounds request issues exactly one memory read, at address `base + vpn * PTE_BYTES`.
- R3: A request whose page number is greater than or equal to the length register returns status 1 (bound error) with `rsp_paddr` = 0. No memory read is issued, and `rsp_valid` rises one cycle after acceptance.
- R4: An entry with bit DATA_W-1 (valid) clear returns status 2 (page fault) with `rsp_paddr` = 0.
- R5: An entry with the valid bit set returns status 0 (success).
- R6: `req_ready` is low from the acceptance edge until the response has been taken with `rsp_ready`.
- R7: A configuration write made while idle takes effect on the next cycle. A request accepted in the same cycle uses the old values. A write made while a translation is in progress changes nothing for that translation and is applied once the block is idle. No new request is accepted until it has been applied.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and its address and status do not change.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the read request stays valid with a stable address.
- R10: After reset the block is idle (`req_ready` 1, `rsp_valid` 0, `mem_req_valid` 0) and both configuration registers are 0, so the first request gets a bound error.
- R11: For an in-bounds request, `rsp_valid` rises 3 + S + L cycles after acceptance. S is the number of cycles `mem_req_ready` is held low, and L is the number of cycles between the read handshake cycle and the `mem_rsp_valid` cycle, minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for both configuration registers |
| cfg_base | input | PA_W (16) | New table base byte address |
| cfg_len | input | VPN_W+1 (15) | New table length in entries |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W (16) | Virtual address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | CPU side takes the result |
| rsp_paddr | output | PA_W (16) | Physical address, 0 on error |
| rsp_status | output | 2 | 0 success, 1 bound error, 2 page fault |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W (16) | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid, one-cycle pulse |
| mem_rsp_data | input | DATA_W (32) | Entry word, valid flag in the top bit |

## Verification
A bound error is due one cycle after the acceptance edge. An in-bounds walk is due 3 + S + L cycles after it, where S is the memory stall and L the memory latency set for that request. The bench drives and samples on falling edges. From the acceptance edge it counts the falling edges until `rsp_valid` is seen, and compares that count with the figure computed from the vector's stall and latency. Address and status are captured on that same falling edge. A parked configuration write is checked through the first request that follows the interrupted walk.

// File: rtl/pt_walker_pkg.sv
// Package: shared encodings for the page table walker.
// Assumes: two-bit status and two-bit state fit every configuration.
package pt_walker_pkg;

    // Result codes returned to the CPU side
    typedef enum logic [1:0] {
        XL_OK    = 2'd0,
        XL_BOUND = 2'd1,
        XL_FAULT = 2'd2
    } xl_status_e;

    // Walk sequencer states
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_READ = 2'd1,
        WS_WAIT = 2'd2,
        WS_RESP = 2'd3
    } walk_state_e;

endpackage

// File: rtl/pt_cfg_regs.sv
// Module: table base and length registers with a deferred-write slot.
// A write while idle lands on the next edge. A write while busy is parked
// and applied on the first idle cycle. The newest write wins.
// Assumes: busy is high for every cycle a walk is in flight.
module pt_cfg_regs #(
    parameter int BASE_W = 16,
    parameter int LEN_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [LEN_W-1:0]  wr_len,
    output logic [BASE_W-1:0] base_q,
    output logic [LEN_W-1:0]  len_q,
    output logic              pend_q
);

    logic [BASE_W-1:0] pend_base;
    logic [LEN_W-1:0]  pend_len;

    // Live registers: load direct writes or the parked write when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
        end else if (!busy) begin
            if (wr_en) begin
                base_q <= wr_base;
                len_q  <= wr_len;
            end else if (pend_q) begin
                base_q <= pend_base;
                len_q  <= pend_len;
            end
        end
    end

    // Parking slot: capture writes that arrive during a walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pend_base <= '0;
            pend_len  <= '0;
        end else if (!busy) begin
            pend_q <= 1'b0;
        end else if (wr_en) begin
            pend_q    <= 1'b1;
            pend_base <= wr_base;
            pend_len  <= wr_len;
        end
    end

    // Registers must not move while a walk uses them
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(base_q) && $stable(len_q)));

    // A parked write reaches the live registers on the first idle edge
    p_pend_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !busy && !wr_en) |=> (!pend_q && base_q == $past(pend_base)
                                          && len_q == $past(pend_len)));

endmodule

// File: rtl/pt_addr_calc.sv
// Module: splits the virtual address, checks the page number against the
// table length and forms the entry byte address. Purely combinational.
// Assumes: PTE_BYTES is a power of two; PA_W >= VPN_W.
module pt_addr_calc #(
    parameter int VA_W      = 16,
    parameter int PA_W      = 16,
    parameter int OFF_W     = 2,
    parameter int PTE_BYTES = 4
) (
    input  logic [VA_W-1:0]       vaddr,
    input  logic [PA_W-1:0]       base,
    input  logic [VA_W-OFF_W:0]   len,
    output logic [OFF_W-1:0]      offset,
    output logic                  out_of_range,
    output logic [PA_W-1:0]       pte_addr
);

    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PTE_SH = $clog2(PTE_BYTES);

    logic [VPN_W-1:0] vpn;
    logic [PA_W-1:0]  vpn_wide;

    // Field split and bounds compare (length is one bit wider than vpn)
    always_comb begin
        vpn          = vaddr[VA_W-1:OFF_W];
        offset       = vaddr[OFF_W-1:0];
        out_of_range = ({1'b0, vpn} >= len);
        vpn_wide     = PA_W'(vpn);
    end

    // Entry address: shift for multi-byte entries, plain add for byte entries
    generate
        if (PTE_SH == 0) begin : g_byte_pte
            always_comb pte_addr = base + vpn_wide;
        end else begin : g_wide_pte
            always_comb pte_addr = base + (vpn_wide << PTE_SH);
        end
    endgenerate

endmodule

// File: rtl/pt_walk_fsm.sv
// Module: sequencer for one walk: accept, read the entry, judge it, and hold
// the result until the CPU takes it. One walk at a time.
// Assumes: memory returns exactly one rsp pulse per accepted read.
module pt_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int PA_W    = 16,
    parameter int OFF_W   = 2,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hold,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              out_of_range,
    input  logic [OFF_W-1:0]  offset,
    input  logic [PA_W-1:0]   pte_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_status,
    output logic              busy
);

    localparam int FRAME_W = PA_W - OFF_W;

    walk_state_e       state_q;
    xl_status_e        status_q;
    logic [PA_W-1:0]   addr_q;
    logic [OFF_W-1:0]  off_q;
    logic [PA_W-1:0]   paddr_q;
    logic              accept;

    // Handshake decode from the current state
    always_comb begin
        req_ready     = (state_q == WS_IDLE) && !cfg_hold;
        accept        = req_valid && req_ready;
        mem_req_valid = (state_q == WS_READ);
        mem_req_addr  = addr_q;
        rsp_valid     = (state_q == WS_RESP);
        rsp_paddr     = paddr_q;
        rsp_status    = status_q;
        busy          = (state_q != WS_IDLE);
    end

    // Walk sequence and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WS_IDLE;
            status_q <= XL_OK;
            addr_q   <= '0;
            off_q    <= '0;
            paddr_q  <= '0;
        end else begin
            case (state_q)
                WS_IDLE: begin
                    if (accept) begin
                        off_q  <= offset;
                        addr_q <= pte_addr;
                        if (out_of_range) begin
                            status_q <= XL_BOUND;
                            paddr_q  <= '0;
                            state_q  <= WS_RESP;
                        end else begin
                            state_q  <= WS_READ;
                        end
                    end
                end
                WS_READ: begin
                    if (mem_req_ready) state_q <= WS_WAIT;
                end
                WS_WAIT: begin
                    if (mem_rsp_valid) begin
                        state_q <= WS_RESP;
                        if (mem_rsp_data[DATA_W-1]) begin
                            status_q <= XL_OK;
                            paddr_q  <= {mem_rsp_data[FRAME_W-1:0], off_q};
                        end else begin
                            status_q <= XL_FAULT;
                            paddr_q  <= '0;
                        end
                    end
                end
                WS_RESP: begin
                    if (rsp_ready) state_q <= WS_IDLE;
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    // Out-of-range request answers next cycle without touching memory
    p_bound_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && out_of_range) |=> (rsp_valid && !mem_req_valid
                                      && rsp_status == 2'd1));

    // Error responses carry a zero address
    p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_paddr == '0));

    // A success only follows a memory response
    p_ok_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && rsp_status == 2'd0) |-> $past(mem_rsp_valid));

    // No acceptance while a result waits
    p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // Result held until taken
    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                       && $stable(rsp_status)));

    // Read request held until taken
    p_memreq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid
                                               && $stable(mem_req_addr)));

endmodule

// File: rtl/pt_walker.sv
// Module: top of the single-level page table walker.
// Wires the configuration registers, the address calculator and the walk
// sequencer. Assumes PAGE_BYTES and PTE_BYTES are powers of two and that
// the frame field fits below the valid bit of an entry.
module pt_walker #(
    parameter int VA_W       = 16,
    parameter int PA_W       = 16,
    parameter int PAGE_BYTES = 4,
    parameter int PTE_BYTES  = 4,
    parameter int DATA_W     = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int VPN_W     = VA_W - OFF_W,
    localparam int LEN_W     = VPN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PA_W-1:0]   cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_status,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    logic              busy;
    logic              cfg_pend;
    logic [PA_W-1:0]   base_q;
    logic [LEN_W-1:0]  len_q;
    logic [OFF_W-1:0]  offset;
    logic              out_of_range;
    logic [PA_W-1:0]   pte_addr;

    pt_cfg_regs #(
        .BASE_W (PA_W),
        .LEN_W  (LEN_W)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr_en   (cfg_we),
        .wr_base (cfg_base),
        .wr_len  (cfg_len),
        .base_q  (base_q),
        .len_q   (len_q),
        .pend_q  (cfg_pend)
    );

    pt_addr_calc #(
        .VA_W      (VA_W),
        .PA_W      (PA_W),
        .OFF_W     (OFF_W),
        .PTE_BYTES (PTE_BYTES)
    ) calc_i (
        .vaddr        (req_vaddr),
        .base         (base_q),
        .len          (len_q),
        .offset       (offset),
        .out_of_range (out_of_range),
        .pte_addr     (pte_addr)
    );

    pt_walk_fsm #(
        .PA_W   (PA_W),
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_hold      (cfg_pend),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .out_of_range  (out_of_range),
        .offset        (offset),
        .pte_addr      (pte_addr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_status    (rsp_status),
        .busy          (busy)
    );

endmodule

// File: tb/pt_walker_tb_top.sv
// Bench: vector table walked by one loop, then directed tests for reset,
// stalls, held responses and deferred configuration writes.
module pt_walker_tb_top;

    typedef struct packed {
        logic [15:0] va;
        logic [15:0] pa;
        logic [1:0]  st;
        logic [3:0]  lat;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{16'h0006, 16'h000E, 2'd0, 4'd0},
        '{16'h0009, 16'h0005, 2'd0, 4'd2},
        '{16'h0000, 16'h0010, 2'd0, 4'd5},
        '{16'h0003, 16'h0013, 2'd0, 4'd1},
        '{16'h000B, 16'h0007, 2'd0, 4'd0},
        '{16'h000D, 16'h0000, 2'd2, 4'd3},
        '{16'h0010, 16'h0000, 2'd1, 4'd0},
        '{16'hFFFF, 16'h0000, 2'd1, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [14:0] cfg_len = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_vaddr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [15:0] rsp_paddr;
    logic [1:0]  rsp_status;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails = 0;
    int mem_lat = 0;
    int stall_left = 0;
    int rd_count = 0;
    logic [15:0] rd_addr = '0;
    int phase = 0;
    int cnt = 0;

    always #4 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_status(rsp_status),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    // Memory contents: first table at 0x40, second at 0x80
    function automatic logic [31:0] pte_word(input logic [15:0] a);
        case (a)
            16'h0040: return 32'h8000_0004;
            16'h0044: return 32'h8000_0003;
            16'h0048: return 32'h8000_0001;
            16'h004C: return 32'h0000_0007;
            16'h0080: return 32'h8000_002A;
            default:  return 32'h0;
        endcase
    endfunction

    // Memory model, acts on falling edges
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            phase = 0;
        end else begin
            mem_rsp_valid = 1'b0;
            if (phase == 0) begin
                if (mem_req_valid) begin
                    if (stall_left > 0) begin
                        mem_req_ready = 1'b0;
                        stall_left--;
                    end else if (!mem_req_ready) begin
                        mem_req_ready = 1'b1;
                        rd_addr = mem_req_addr;
                        rd_count++;
                        cnt = mem_lat;
                        phase = 1;
                    end
                end
            end else begin
                mem_req_ready = 1'b0;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = pte_word(rd_addr);
                    phase = 0;
                end else begin
                    cnt--;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] b, input logic [14:0] l);
        cfg_we = 1'b1;
        cfg_base = b;
        cfg_len = l;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One translation; hold = cycles to keep rsp_ready low after rsp_valid
    task automatic xlate(input logic [15:0] va, input int hold,
                         output logic [15:0] pa, output logic [1:0] st,
                         output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        chk("R6 req_ready after accept", {31'd0, req_ready}, 32'd0);
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        pa = rsp_paddr;
        st = rsp_status;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R8 rsp held", {15'd0, rsp_valid, rsp_paddr}, {15'd0, 1'b1, pa});
            chk("R8 status held", {30'd0, rsp_status}, {30'd0, st});
            chk("R6 busy while held", {31'd0, req_ready}, 32'd0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    // Watchdog: a hang counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] pa;
        logic [1:0]  st;
        int          lat;
        int          rc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R10 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        rc = rd_count;
        xlate(16'h0006, 0, pa, st, lat);
        chk("R10 length zero gives bound", {30'd0, st}, 32'd1);
        chk("R10 no read", rd_count, rc);

        // R7 idle write lands at once
        cfg_write(16'h0040, 15'd4);

        for (int i = 0; i < NVEC; i++) begin
            mem_lat = int'(VEC[i].lat);
            rc = rd_count;
            xlate(VEC[i].va, 0, pa, st, lat);
            chk("R1 paddr", {16'd0, pa}, {16'd0, VEC[i].pa});
            if (VEC[i].st == 2'd1) begin
                chk("R3 status", {30'd0, st}, 32'd1);
                chk("R3 no read", rd_count, rc);
                chk("R3 latency", lat, 1);
            end else begin
                if (VEC[i].st == 2'd2)
                    chk("R4 status", {30'd0, st}, 32'd2);
                else
                    chk("R5 status", {30'd0, st}, 32'd0);
                chk("R2 one read", rd_count, rc + 1);
                chk("R2 entry address", {16'd0, rd_addr},
                    {16'd0, 16'h0040 + ((VEC[i].va >> 2) << 2)});
                chk("R11 latency", lat, 3 + int'(VEC[i].lat));
            end
        end

        // R9 stalled read request, R8 held response
        mem_lat = 1;
        stall_left = 3;
        xlate(16'h0009, 3, pa, st, lat);
        chk("R9 paddr after stall", {16'd0, pa}, 32'h5);
        chk("R9 address after stall", {16'd0, rd_addr}, 32'h48);
        chk("R9 latency with stall", lat, 3 + 1 + 3);

        // R7 write during a walk is parked
        mem_lat = 10;
        fork
            xlate(16'h0006, 0, pa, st, lat);
            begin
                repeat (4) @(negedge clk);
                cfg_write(16'h0080, 15'd1);
            end
        join
        chk("R7 walk uses old table", {16'd0, pa}, 32'hE);
        mem_lat = 0;
        xlate(16'h0003, 0, pa, st, lat);
        chk("R7 new base applied", {16'd0, pa}, 32'hAB);
        chk("R7 new base address", {16'd0, rd_addr}, 32'h80);
        xlate(16'h0004, 0, pa, st, lat);
        chk("R7 new length applied", {30'd0, st}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule